// File: doc/BRIEF.md
# Stack Processor Execution Unit

This block is the arithmetic and logic unit of a 32-bit zero-address stack processor. Each operation reads the two words at the top of the stack: A, the word on top, and B, the word beneath it. An 8-bit opcode selects the operation. The unit returns one result word and a flag that tells the stack control whether the operation consumed only A or consumed both A and B. The stack control then pushes the result in place of the consumed words.

The unit covers bitwise logic, add, subtract and negate, equality tests, and signed and unsigned ordering tests. It also covers three shifts, a 32-bit bit reversal, a halfword exchange, a full multiply and a 16x16 multiply. The opcode and both operands are captured when a valid strobe is high. The result, the operand-count flag and an illegal-opcode flag appear one clock later together with a result strobe. They keep their values until the next valid operation.

Top module: `stk_alu`

## Requirements
- R1: Opcode 7 gives A|B, opcode 6 gives A&B and opcode 50 gives A^B. Opcode 9 gives ~A.
- R2: Opcode 5 gives A+B, opcode 49 gives B-A and opcode 48 gives -A. All three wrap modulo 2^32.
- R3: Each compare gives 1 when true and 0 when false, and bits 31..1 of the result are always zero. Opcode 46 tests A==B and opcode 47 tests A!=B. Opcode 36 tests A<B and opcode 37 tests A<=B, both as signed numbers. Opcode 38 tests A<B and opcode 39 tests A<=B, both as unsigned numbers.
- R4: For opcodes 42 (logical right), 43 (left) and 44 (arithmetic right), B is the value and A[5:0] is the shift amount. Bits A[31:6] are ignored. The left shift and the logical right shift fill with zeros. The arithmetic right shift fills with B[31].
- R5: A shift amount from 32 to 63 gives 0 for opcodes 42 and 43. For opcode 44 it gives 32 copies of B[31].
- R6: Opcode 10 moves bit j of A to bit 31-j. Opcode 40 gives {A[15:0], A[31:16]}.
- R7: Opcode 41 gives the low 32 bits of A*B. Opcode 62 gives the full 32-bit product A[15:0]*B[15:0], with both factors unsigned.
- R8: The `unary` output is 1 for opcodes 9 and 48 only. It is 0 for every other opcode, including illegal ones.
- R9: `result_valid` equals `op_valid` from one clock earlier. `result`, `unary` and `illegal_op` change only at a clock edge where `op_valid` is high, and they hold their values otherwise.
- R10: An opcode outside the 20 listed above sets `illegal_op` to 1 and `result` to 0.
- R11: While reset is asserted, `result_valid`, `result`, `unary` and `illegal_op` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| op_valid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Operation select |
| opnd_a | input | 32 | Top-of-stack word A |
| opnd_b | input | 32 | Second stack word B |
| result_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 32 | Result word |
| unary | output | 1 | 1 when the operation consumed only A |
| illegal_op | output | 1 | 1 when the opcode is not supported |

## Verification
Two things can happen in the same clock edge. The unit captures a new operation while it is still presenting the result of the previous one. When operations arrive back to back, the strobe stays high, and every edge must replace the result, the operand-count flag and the illegal flag together. None of them may keep a stale value from the previous operation. The bench provokes this with long runs of back-to-back operations. It places illegal opcodes directly after legal ones and the reverse, and it inserts random idle cycles. In each cycle it compares all four outputs against a bench model. In idle cycles it checks that the outputs from the last operation are held.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

  localparam int unsigned OPC_W = 8;

  // Opcode values as seen on the opcode port
  localparam logic [OPC_W-1:0] OPC_ADD   = 8'd5;
  localparam logic [OPC_W-1:0] OPC_AND   = 8'd6;
  localparam logic [OPC_W-1:0] OPC_OR    = 8'd7;
  localparam logic [OPC_W-1:0] OPC_NOT   = 8'd9;
  localparam logic [OPC_W-1:0] OPC_REV   = 8'd10;
  localparam logic [OPC_W-1:0] OPC_LTS   = 8'd36;
  localparam logic [OPC_W-1:0] OPC_LES   = 8'd37;
  localparam logic [OPC_W-1:0] OPC_LTU   = 8'd38;
  localparam logic [OPC_W-1:0] OPC_LEU   = 8'd39;
  localparam logic [OPC_W-1:0] OPC_HSWP  = 8'd40;
  localparam logic [OPC_W-1:0] OPC_MUL   = 8'd41;
  localparam logic [OPC_W-1:0] OPC_SRL   = 8'd42;
  localparam logic [OPC_W-1:0] OPC_SLL   = 8'd43;
  localparam logic [OPC_W-1:0] OPC_SRA   = 8'd44;
  localparam logic [OPC_W-1:0] OPC_EQ    = 8'd46;
  localparam logic [OPC_W-1:0] OPC_NE    = 8'd47;
  localparam logic [OPC_W-1:0] OPC_NEG   = 8'd48;
  localparam logic [OPC_W-1:0] OPC_SUB   = 8'd49;
  localparam logic [OPC_W-1:0] OPC_XOR   = 8'd50;
  localparam logic [OPC_W-1:0] OPC_MULH  = 8'd62;

  typedef enum logic [4:0] {
    CL_NONE, CL_OR, CL_AND, CL_XOR, CL_NOT,
    CL_ADD, CL_SUB, CL_NEG,
    CL_EQ, CL_NE, CL_LTS, CL_LES, CL_LTU, CL_LEU,
    CL_REV, CL_HSWP, CL_MUL, CL_MULH,
    CL_SRL, CL_SLL, CL_SRA
  } op_class_e;

  typedef enum logic [1:0] {
    SH_LEFT, SH_LRIGHT, SH_ARIGHT
  } shift_mode_e;

  typedef struct packed {
    op_class_e cls;
    logic      unary;
    logic      legal;
  } op_dec_t;

endpackage

// File: rtl/stk_alu_decode.sv
module stk_alu_decode
  import stk_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_dec_t          dec
);

  always_comb begin
    dec.cls   = CL_NONE;
    dec.unary = 1'b0;
    dec.legal = 1'b1;
    case (opcode)
      OPC_OR:   dec.cls = CL_OR;
      OPC_AND:  dec.cls = CL_AND;
      OPC_XOR:  dec.cls = CL_XOR;
      OPC_NOT:  begin dec.cls = CL_NOT; dec.unary = 1'b1; end
      OPC_ADD:  dec.cls = CL_ADD;
      OPC_SUB:  dec.cls = CL_SUB;
      OPC_NEG:  begin dec.cls = CL_NEG; dec.unary = 1'b1; end
      OPC_EQ:   dec.cls = CL_EQ;
      OPC_NE:   dec.cls = CL_NE;
      OPC_LTS:  dec.cls = CL_LTS;
      OPC_LES:  dec.cls = CL_LES;
      OPC_LTU:  dec.cls = CL_LTU;
      OPC_LEU:  dec.cls = CL_LEU;
      OPC_REV:  dec.cls = CL_REV;
      OPC_HSWP: dec.cls = CL_HSWP;
      OPC_MUL:  dec.cls = CL_MUL;
      OPC_MULH: dec.cls = CL_MULH;
      OPC_SRL:  dec.cls = CL_SRL;
      OPC_SLL:  dec.cls = CL_SLL;
      OPC_SRA:  dec.cls = CL_SRA;
      default:  dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/stk_alu_arith.sv
module stk_alu_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic [W-1:0] neg,
  output logic [W-1:0] prod,
  output logic [W-1:0] prod_half,
  output logic         eq,
  output logic         lt_s,
  output logic         le_s,
  output logic         lt_u,
  output logic         le_u
);

  localparam int unsigned HW = W / 2;

  logic [W-1:0] a_lo_ext;
  logic [W-1:0] b_lo_ext;

  always_comb begin
    a_lo_ext  = {{(W-HW){1'b0}}, a[HW-1:0]};
    b_lo_ext  = {{(W-HW){1'b0}}, b[HW-1:0]};
    sum       = a + b;
    diff      = b - a;          // second word minus top word
    neg       = '0 - a;
    prod      = a * b;
    prod_half = a_lo_ext * b_lo_ext;
    eq        = (a == b);
    lt_s      = ($signed(a) <  $signed(b));
    le_s      = ($signed(a) <= $signed(b));
    lt_u      = (a <  b);
    le_u      = (a <= b);
  end

endmodule

// File: rtl/stk_alu_shift.sv
module stk_alu_shift
  import stk_alu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = 6
) (
  input  logic [W-1:0]     value,
  input  logic [AMT_W-1:0] amt,
  input  shift_mode_e      mode,
  output logic [W-1:0]     shifted
);

  logic [W-1:0] stg [0:AMT_W];

  assign stg[0] = value;

  // Logarithmic shifter: stage i moves by 2**i when amt[i] is set.
  // Stages whose distance reaches W give a full fill on their own.
  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int unsigned SH = 1 << i;
    logic [W-1:0] moved;
    always_comb begin
      case (mode)
        SH_LEFT:   moved = stg[i] << SH;
        SH_LRIGHT: moved = stg[i] >> SH;
        default:   moved = $unsigned($signed(stg[i]) >>> SH);
      endcase
    end
    assign stg[i+1] = amt[i] ? moved : stg[i];
  end

  assign shifted = stg[AMT_W];

endmodule

// File: rtl/stk_alu_bitperm.sv
module stk_alu_bitperm #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] reversed,
  output logic [W-1:0] half_swapped
);

  localparam int unsigned HW = W / 2;

  for (genvar j = 0; j < W; j++) begin : g_rev
    assign reversed[W-1-j] = a[j];
  end

  assign half_swapped = {a[HW-1:0], a[W-1:HW]};

endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_alu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned AMT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  output logic             result_valid,
  output logic [W-1:0]     result,
  output logic             unary,
  output logic             illegal_op
);

  // ---------------- reset release synchronizer ----------------
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // ---------------- datapath ----------------
  op_dec_t     dec;
  shift_mode_e sh_mode;
  logic [W-1:0] sum, diff, neg, prod, prod_half, shifted, reversed, half_swapped;
  logic eq, lt_s, le_s, lt_u, le_u;

  stk_alu_decode u_decode (
    .opcode (opcode),
    .dec    (dec)
  );

  stk_alu_arith #(.W(W)) u_arith (
    .a         (opnd_a),
    .b         (opnd_b),
    .sum       (sum),
    .diff      (diff),
    .neg       (neg),
    .prod      (prod),
    .prod_half (prod_half),
    .eq        (eq),
    .lt_s      (lt_s),
    .le_s      (le_s),
    .lt_u      (lt_u),
    .le_u      (le_u)
  );

  always_comb begin
    case (dec.cls)
      CL_SLL:  sh_mode = SH_LEFT;
      CL_SRA:  sh_mode = SH_ARIGHT;
      default: sh_mode = SH_LRIGHT;
    endcase
  end

  stk_alu_shift #(.W(W), .AMT_W(AMT_W)) u_shift (
    .value   (opnd_b),
    .amt     (opnd_a[AMT_W-1:0]),
    .mode    (sh_mode),
    .shifted (shifted)
  );

  stk_alu_bitperm #(.W(W)) u_bitperm (
    .a            (opnd_a),
    .reversed     (reversed),
    .half_swapped (half_swapped)
  );

  // ---------------- next-state selection ----------------
  logic [W-1:0] res_d;
  logic         unary_d;
  logic         illegal_d;

  function automatic logic [W-1:0] flag_word(input logic f);
    return {{(W-1){1'b0}}, f};
  endfunction

  always_comb begin
    case (dec.cls)
      CL_OR:   res_d = opnd_a | opnd_b;
      CL_AND:  res_d = opnd_a & opnd_b;
      CL_XOR:  res_d = opnd_a ^ opnd_b;
      CL_NOT:  res_d = ~opnd_a;
      CL_ADD:  res_d = sum;
      CL_SUB:  res_d = diff;
      CL_NEG:  res_d = neg;
      CL_EQ:   res_d = flag_word(eq);
      CL_NE:   res_d = flag_word(!eq);
      CL_LTS:  res_d = flag_word(lt_s);
      CL_LES:  res_d = flag_word(le_s);
      CL_LTU:  res_d = flag_word(lt_u);
      CL_LEU:  res_d = flag_word(le_u);
      CL_REV:  res_d = reversed;
      CL_HSWP: res_d = half_swapped;
      CL_MUL:  res_d = prod;
      CL_MULH: res_d = prod_half;
      CL_SRL, CL_SLL, CL_SRA: res_d = shifted;
      default: res_d = '0;
    endcase
    unary_d   = dec.unary & dec.legal;
    illegal_d = !dec.legal;
  end

  // ---------------- output registers ----------------
  logic         res_valid_q;
  logic [W-1:0] res_q;
  logic         unary_q;
  logic         illegal_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
      unary_q     <= 1'b0;
      illegal_q   <= 1'b0;
    end else begin
      res_valid_q <= op_valid;
      if (op_valid) begin
        res_q     <= res_d;
        unary_q   <= unary_d;
        illegal_q <= illegal_d;
      end
    end
  end

  assign result_valid = res_valid_q;
  assign result       = res_q;
  assign unary        = unary_q;
  assign illegal_op   = illegal_q;

  // ---------------- assertions ----------------
  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal_op |-> (result == '0 && !unary));

  assert_unary_set_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (opcode == OPC_NOT || opcode == OPC_NEG)) |=> unary);

  assert_strobe_lag_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    result_valid |-> $past(op_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> ($stable(result) && $stable(unary) && $stable(illegal_op)));

  assert_cmp_bool_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && opcode >= OPC_LTS && opcode <= OPC_LEU) |=> (result[W-1:1] == '0));

  assert_far_shift_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (opcode == OPC_SRL || opcode == OPC_SLL) && opnd_a[AMT_W-1]) |=> (result == '0));

  assert_sra_fill_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && opcode == OPC_SRA && opnd_a[AMT_W-1]) |=> (result == {W{$past(opnd_b[W-1])}}));

endmodule

// File: tb/test_stk_alu.sv
module test_stk_alu;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  opcode;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        result_valid;
  logic [31:0] result;
  logic        unary;
  logic        illegal_op;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [33:0] last_exp = '0;

  stk_alu i_stk_alu (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .opcode       (opcode),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .result_valid (result_valid),
    .result       (result),
    .unary        (unary),
    .illegal_op   (illegal_op)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [7:0] LEGAL [20] = '{8'd5, 8'd6, 8'd7, 8'd9, 8'd10, 8'd36, 8'd37,
    8'd38, 8'd39, 8'd40, 8'd41, 8'd42, 8'd43, 8'd44, 8'd46, 8'd47, 8'd48, 8'd49,
    8'd50, 8'd62};

  // {illegal, unary, result}
  function automatic logic [33:0] model(input logic [7:0] opc, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic il, un;
    int amt;
    r = '0; il = 1'b0; un = 1'b0;
    amt = int'(a[5:0]);
    case (opc)
      8'd7:  r = a | b;
      8'd6:  r = a & b;
      8'd50: r = a ^ b;
      8'd9:  begin r = ~a; un = 1'b1; end
      8'd5:  r = a + b;
      8'd49: r = b - a;
      8'd48: begin r = 32'd0 - a; un = 1'b1; end
      8'd46: r = (a == b) ? 32'd1 : 32'd0;
      8'd47: r = (a != b) ? 32'd1 : 32'd0;
      8'd36: r = ($signed(a) <  $signed(b)) ? 32'd1 : 32'd0;
      8'd37: r = ($signed(a) <= $signed(b)) ? 32'd1 : 32'd0;
      8'd38: r = (a <  b) ? 32'd1 : 32'd0;
      8'd39: r = (a <= b) ? 32'd1 : 32'd0;
      8'd42: r = (amt >= 32) ? 32'd0 : (b >> amt);
      8'd43: r = (amt >= 32) ? 32'd0 : (b << amt);
      8'd44: r = (amt >= 32) ? {32{b[31]}} : $unsigned($signed(b) >>> amt);
      8'd10: for (int j = 0; j < 32; j++) r[31-j] = a[j];
      8'd40: r = {a[15:0], a[31:16]};
      8'd41: r = a * b;
      8'd62: r = {16'd0, a[15:0]} * {16'd0, b[15:0]};
      default: il = 1'b1;
    endcase
    return {il, un, r};
  endfunction

  function automatic string req_of(input logic [7:0] opc);
    case (opc)
      8'd7, 8'd6, 8'd50, 8'd9:          return "R1";
      8'd5, 8'd49, 8'd48:               return "R2";
      8'd46, 8'd47, 8'd36, 8'd37, 8'd38, 8'd39: return "R3";
      8'd42, 8'd43, 8'd44:              return "R4";
      8'd10, 8'd40:                     return "R6";
      8'd41, 8'd62:                     return "R7";
      default:                          return "R10";
    endcase
  endfunction

  task automatic compare(input string req, input logic [34:0] act, input logic [34:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,illegal,unary,result} actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] opc, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [33:0] e;
    @(negedge clk);
    op_valid = 1'b1; opcode = opc; opnd_a = a; opnd_b = b;
    e = model(opc, a, b);
    @(posedge clk); #1;
    compare(req, {result_valid, illegal_op, unary, result}, {1'b1, e});
    if (unary !== e[32]) begin
      n_vec++; n_fail++;
      $display("FAIL R8: unary actual=%b expected=%b", unary, e[32]);
    end
    last_exp = e;
  endtask

  // R9: idle cycle, inputs scrambled, outputs must hold and strobe drop
  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0; opcode = 8'($urandom); opnd_a = $urandom; opnd_b = $urandom;
    @(posedge clk); #1;
    compare("R9", {result_valid, illegal_op, unary, result}, {1'b0, last_exp});
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid = 1'b1; opcode = 8'd5; opnd_a = 32'd3; opnd_b = 32'd4;
    repeat (4) @(posedge clk);
    #1;
    // R11: outputs cleared during reset even with op_valid high
    compare("R11", {result_valid, illegal_op, unary, result}, 35'd0);
    @(negedge clk); op_valid = 1'b0; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 / R2 directed
    issue(8'd7,  32'hF0F0_0000, 32'h0000_0F0F, "R1");
    issue(8'd9,  32'h1234_5678, 32'hFFFF_FFFF, "R1");
    issue(8'd49, 32'd5, 32'd3, "R2");               // B-A = -2
    issue(8'd48, 32'h8000_0000, 32'd0, "R2");
    issue(8'd5,  32'hFFFF_FFFF, 32'd1, "R2");
    // R3 signed vs unsigned with negative A
    issue(8'd36, 32'hFFFF_FFFF, 32'd1, "R3");       // -1 < 1 -> 1
    issue(8'd38, 32'hFFFF_FFFF, 32'd1, "R3");       // unsigned -> 0
    issue(8'd37, 32'd7, 32'd7, "R3");
    issue(8'd39, 32'd8, 32'd7, "R3");
    issue(8'd47, 32'd8, 32'd8, "R3");
    // R4: upper amount bits ignored
    issue(8'd43, 32'hFFFF_FF44, 32'h0000_0001, "R4"); // amt 4
    issue(8'd44, 32'd4, 32'h8000_0010, "R4");
    issue(8'd42, 32'd0, 32'hDEAD_BEEF, "R4");
    // R5: far shifts
    issue(8'd42, 32'd32, 32'hFFFF_FFFF, "R5");
    issue(8'd43, 32'd63, 32'hFFFF_FFFF, "R5");
    issue(8'd44, 32'd40, 32'h8000_0000, "R5");
    issue(8'd44, 32'd33, 32'h7FFF_FFFF, "R5");
    // R6 / R7
    issue(8'd10, 32'h0000_0001, 32'd0, "R6");
    issue(8'd40, 32'hAAAA_5555, 32'd0, "R6");
    issue(8'd41, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
    issue(8'd62, 32'h1234_FFFF, 32'h5678_FFFF, "R7");
    // R10 right after a legal op, then legal right after illegal
    issue(8'd0,   32'd9, 32'd9, "R10");
    issue(8'd255, 32'd9, 32'd9, "R10");
    issue(8'd9,   32'd0, 32'd0, "R8");
    issue(8'd45,  32'd1, 32'd2, "R10");
    idle();
    idle();

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] opc;
      logic [31:0] a, b;
      if ($urandom_range(9) == 0) idle();
      opc = ($urandom_range(7) == 0) ? 8'($urandom) : LEGAL[$urandom_range(19)];
      a = $urandom; b = $urandom;
      if ($urandom_range(3) == 0) a = 32'($urandom_range(70));
      if ($urandom_range(5) == 0) b = a;
      issue(opc, a, b, req_of(opc));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule